// File: doc/BRIEF.md
# Host-to-Responder Command Mailbox

This block is a memory-mapped mailbox between a host processor and a management microcontroller (the responder). The host posts a 32-bit command word and up to 16 bytes of request data over a simple 32-bit register bus. It then watches a status word until the responder reports that the command has finished. The responder is woken by a one-cycle doorbell pulse. It reads the latched command word and the outbound data through its own port, writes any response into the inbound buffer, and finishes with a one-cycle completion strobe that carries an error flag and an 8-bit error code.

Each command can ask for a host interrupt when it completes. A command posted while a previous one is still in flight is dropped, and a sticky flag in the status word records the drop. Host reads return data one cycle after the request. The inbound buffer can be read as whole words or as single bytes.

Top module: `ipc_mbox`

## Requirements
- R1: After reset the status word reads as the initiator id in bits 15:8 with every other bit zero, and neither the doorbell nor the host interrupt is asserted.
- R2: A host write to offset 0x00 while idle sets busy (status bit 0) on the next clock edge. On that same edge it raises `rsp_doorbell` for exactly one cycle and latches the written word onto `rsp_cmd`. Command fields: code in bits 7:0, interrupt request in bit 8, sub-command id in bits 15:12, byte count in bits 23:16.
- R3: `rsp_cmd` keeps its value while busy is set.
- R4: A completion strobe while busy does three things on the same edge: it clears busy, loads the error flag into status bit 1, and loads the error code into status bits 23:16. Status bits 7:4 echo the sub-command id of the command that was accepted. Accepting a new command clears the error flag and the error code.
- R5: A command write while busy does not change `rsp_cmd` and does not ring the doorbell. It sets status bit 2, which stays set until reset.
- R6: A host write to offset 0x80+4k stores the word in outbound slot k. The responder reads slot k on `rsp_obuf_rdata` one cycle after it presents k on `rsp_obuf_raddr`.
- R7: Words the responder writes into inbound slot k are read by the host at 0x90+4k. With `host_rd_byte` set, a read at 0x90+n returns byte n of the buffer (little-endian within each word) in bits 7:0, with zeros above. `host_rvalid` rises one cycle after `host_rd_en`.
- R8: When the accepted command had bit 8 set, `host_irq` pulses for one cycle on the edge that clears busy. When bit 8 was clear, `host_irq` stays low.
- R9: Reads of any offset other than the status word and the inbound buffer return zero. This includes 0x00 and the outbound buffer. Host writes to the status word or to the inbound buffer change nothing.
- R10: A completion strobe while idle changes nothing in the status word and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_byte | input | 1 | Host read returns a single byte |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd_en |
| host_irq | output | 1 | Completion interrupt pulse to host |
| rsp_doorbell | output | 1 | One-cycle pulse when a command is accepted |
| rsp_cmd | output | 32 | Latched command word |
| rsp_obuf_raddr | input | SLOT_W | Responder outbound slot index |
| rsp_obuf_rdata | output | 32 | Outbound slot contents, one cycle latency |
| rsp_ibuf_we | input | 1 | Responder inbound write strobe |
| rsp_ibuf_waddr | input | SLOT_W | Responder inbound slot index |
| rsp_ibuf_wdata | input | 32 | Responder inbound write data |
| rsp_done | input | 1 | Completion strobe |
| rsp_err | input | 1 | Error flag carried by the completion strobe |
| rsp_err_code | input | 8 | Error code carried by the completion strobe |

## Verification
The bench targets a command that arrives while the mailbox is busy. A design that accepted it would overwrite `rsp_cmd` and ring the doorbell a second time, and a design that failed to latch the drop flag would lose the record of it. A stray completion strobe in the idle state is also driven. A design that does not gate completion on busy would overwrite the error fields and could raise an interrupt. Byte reads at odd inbound offsets catch a wrong lane order. Reads of write-only locations, and writes to read-only ones, expose a loose address decoder. A command with the interrupt request followed by one without it shows whether the request bit is tracked per command or left stale.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam logic [7:0] OFF_CMD  = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_OBUF = 8'h80;
  localparam logic [7:0] OFF_IBUF = 8'h90;

  typedef enum logic [1:0] {RSEL_NONE, RSEL_STAT, RSEL_IBUF} rsel_t;

  typedef struct packed {
    logic [7:0] spare_hi;
    logic [7:0] nbytes;
    logic [3:0] sub_id;
    logic [2:0] spare_lo;
    logic       want_irq;
    logic [7:0] opcode;
  } cmd_word_t;
endpackage

// File: rtl/ipc_mbox_buf.sv
module ipc_mbox_buf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ipc_mbox_ctl.sv
module ipc_mbox_ctl
  import ipc_mbox_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'h5A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        done,
  input  logic        done_err,
  input  logic [7:0]  done_code,
  output logic        busy,
  output logic        doorbell,
  output logic        irq,
  output logic [31:0] cmd_word,
  output logic [31:0] status
);
  cmd_word_t  cw;
  logic       busy_q, bell_q, irq_q, ioc_q, ovr_q, err_q;
  logic [3:0] sub_q;
  logic [7:0] code_q;
  logic [31:0] cmd_q;

  assign cw = cmd_word_t'(cmd_wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bell_q <= 1'b0;
      irq_q  <= 1'b0;
      ioc_q  <= 1'b0;
      ovr_q  <= 1'b0;
      err_q  <= 1'b0;
      sub_q  <= '0;
      code_q <= '0;
      cmd_q  <= '0;
    end else begin
      bell_q <= 1'b0;
      irq_q  <= 1'b0;
      if (cmd_wr && busy_q) ovr_q <= 1'b1;
      if (cmd_wr && !busy_q) begin
        busy_q <= 1'b1;
        bell_q <= 1'b1;
        cmd_q  <= cmd_wdata;
        ioc_q  <= cw.want_irq;
        sub_q  <= cw.sub_id;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (done && busy_q) begin
        busy_q <= 1'b0;
        err_q  <= done_err;
        code_q <= done_code;
        irq_q  <= ioc_q;
      end
    end
  end

  assign busy     = busy_q;
  assign doorbell = bell_q;
  assign irq      = irq_q;
  assign cmd_word = cmd_q;
  assign status   = {8'h00, code_q, INIT_ID, sub_q, 1'b0, ovr_q, err_q, busy_q};

  AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (rst) bell_q |=> !bell_q); // R2
  AST_BELL_BUSY: assert property (@(posedge clk) disable iff (rst) bell_q |-> busy_q); // R2
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst) (busy_q && $past(busy_q)) |-> $stable(cmd_q)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) ovr_q |=> ovr_q); // R5
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (rst) irq_q |-> (!busy_q && $past(busy_q))); // R8
endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         BUF_BYTES = 16,
  parameter logic [7:0] INIT_ID   = 8'h5A,
  parameter int         SLOTS     = BUF_BYTES / 4,
  parameter int         SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic              host_rd_byte,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              host_irq,
  output logic              rsp_doorbell,
  output logic [31:0]       rsp_cmd,
  input  logic [SLOT_W-1:0] rsp_obuf_raddr,
  output logic [31:0]       rsp_obuf_rdata,
  input  logic              rsp_ibuf_we,
  input  logic [SLOT_W-1:0] rsp_ibuf_waddr,
  input  logic [31:0]       rsp_ibuf_wdata,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_err_code
);
  localparam int BUF_AW = $clog2(BUF_BYTES);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'(OFF_OBUF);
  localparam logic [ADDR_W-1:0] A_IBUF = ADDR_W'(OFF_IBUF);

  logic cmd_hit, stat_hit, obuf_hit, ibuf_hit;
  logic [SLOT_W-1:0] host_slot;
  logic        busy;
  logic [31:0] status, ibuf_rdata;

  assign cmd_hit   = host_addr[ADDR_W-1:2] == A_CMD[ADDR_W-1:2];
  assign stat_hit  = host_addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2];
  assign obuf_hit  = host_addr[ADDR_W-1:BUF_AW] == A_OBUF[ADDR_W-1:BUF_AW];
  assign ibuf_hit  = host_addr[ADDR_W-1:BUF_AW] == A_IBUF[ADDR_W-1:BUF_AW];
  assign host_slot = SLOT_W'(host_addr[BUF_AW-1:2]);

  ipc_mbox_ctl #(.INIT_ID(INIT_ID)) ctl_i (
    .clk(clk), .rst(rst),
    .cmd_wr(host_wr_en && cmd_hit), .cmd_wdata(host_wdata),
    .done(rsp_done), .done_err(rsp_err), .done_code(rsp_err_code),
    .busy(busy), .doorbell(rsp_doorbell), .irq(host_irq),
    .cmd_word(rsp_cmd), .status(status)
  );

  ipc_mbox_buf #(.WORDS(SLOTS), .DW(32), .AW(SLOT_W)) obuf_i (
    .clk(clk), .we(host_wr_en && obuf_hit), .waddr(host_slot), .wdata(host_wdata),
    .re(1'b1), .raddr(rsp_obuf_raddr), .rdata(rsp_obuf_rdata)
  );

  ipc_mbox_buf #(.WORDS(SLOTS), .DW(32), .AW(SLOT_W)) ibuf_i (
    .clk(clk), .we(rsp_ibuf_we), .waddr(rsp_ibuf_waddr), .wdata(rsp_ibuf_wdata),
    .re(host_rd_en && ibuf_hit), .raddr(host_slot), .rdata(ibuf_rdata)
  );

  rsel_t       sel_q;
  logic [1:0]  lane_q;
  logic        byte_q, rvalid_q;
  logic [31:0] stat_q, word;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= RSEL_NONE;
      lane_q   <= '0;
      byte_q   <= 1'b0;
      rvalid_q <= 1'b0;
      stat_q   <= '0;
    end else begin
      rvalid_q <= host_rd_en;
      if (host_rd_en) begin
        sel_q  <= stat_hit ? RSEL_STAT : (ibuf_hit ? RSEL_IBUF : RSEL_NONE);
        lane_q <= host_addr[1:0];
        byte_q <= host_rd_byte;
        stat_q <= status;
      end
    end
  end

  always_comb begin
    case (sel_q)
      RSEL_STAT: word = stat_q;
      RSEL_IBUF: word = ibuf_rdata;
      default:   word = '0;
    endcase
    host_rdata = byte_q ? {24'h0, word[8*lane_q +: 8]} : word;
  end

  assign host_rvalid = rvalid_q;

  AST_RVALID_LAG: assert property (@(posedge clk) disable iff (rst) host_rd_en |=> host_rvalid); // R7
  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) (rsp_done && !busy) |=> !host_irq); // R10
endmodule

// File: tb/ipc_mbox_tb_top.sv
module ipc_mbox_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        host_wr_en = 0, host_rd_en = 0, host_rd_byte = 0;
  logic [7:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic        host_rvalid, host_irq, rsp_doorbell;
  logic [31:0] rsp_cmd, rsp_obuf_rdata;
  logic [1:0]  rsp_obuf_raddr = 0, rsp_ibuf_waddr = 0;
  logic        rsp_ibuf_we = 0, rsp_done = 0, rsp_err = 0;
  logic [31:0] rsp_ibuf_wdata = 0;
  logic [7:0]  rsp_err_code = 0;

  ipc_mbox dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_rd_byte(host_rd_byte), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_irq(host_irq),
    .rsp_doorbell(rsp_doorbell), .rsp_cmd(rsp_cmd), .rsp_obuf_raddr(rsp_obuf_raddr),
    .rsp_obuf_rdata(rsp_obuf_rdata), .rsp_ibuf_we(rsp_ibuf_we),
    .rsp_ibuf_waddr(rsp_ibuf_waddr), .rsp_ibuf_wdata(rsp_ibuf_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_err_code(rsp_err_code)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected read value for every returned read
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) chk("RD-unexpected", host_rdata, 32'hxxxxxxxx);
      else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic host_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic host_rd(logic [7:0] a, bit by, logic [31:0] exp, string tag);
    @(negedge clk);
    host_rd_en = 1; host_addr = a; host_rd_byte = by;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd_en = 0; host_rd_byte = 0;
  endtask

  task automatic rsp_finish(bit e, logic [7:0] c);
    @(negedge clk);
    rsp_done = 1; rsp_err = e; rsp_err_code = c;
    @(negedge clk);
    rsp_done = 0; rsp_err = 0; rsp_err_code = 0;
  endtask

  task automatic rsp_ib(logic [1:0] k, logic [31:0] d);
    @(negedge clk);
    rsp_ibuf_we = 1; rsp_ibuf_waddr = k; rsp_ibuf_wdata = d;
    @(negedge clk);
    rsp_ibuf_we = 0;
  endtask

  task automatic rsp_ob_chk(logic [1:0] k, logic [31:0] exp);
    @(negedge clk);
    rsp_obuf_raddr = k;
    @(negedge clk);
    chk("R6 outbound slot", rsp_obuf_rdata, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 doorbell", {31'h0, rsp_doorbell}, 0);
    chk("R1 irq", {31'h0, host_irq}, 0);
    host_rd(8'h04, 0, 32'h00005A00, "R1 status");

    // write-style command: outbound data then command
    host_wr(8'h80, 32'h00300012);
    host_wr(8'h84, 32'h000000A5);
    rsp_ob_chk(2'd0, 32'h00300012);
    rsp_ob_chk(2'd1, 32'h000000A5);
    host_wr(8'h00, 32'h000300FF);
    chk("R2 doorbell high", {31'h0, rsp_doorbell}, 1);
    chk("R2 cmd latched", rsp_cmd, 32'h000300FF);
    @(negedge clk);
    chk("R2 doorbell single", {31'h0, rsp_doorbell}, 0);
    host_rd(8'h04, 0, 32'h00005A01, "R2 busy");

    // R5 overrun: command while busy
    host_wr(8'h00, 32'h000011AA);
    chk("R5 no doorbell", {31'h0, rsp_doorbell}, 0);
    repeat (3) @(negedge clk);
    chk("R3 cmd held", rsp_cmd, 32'h000300FF);
    host_rd(8'h04, 0, 32'h00005A05, "R5 overrun flag");

    rsp_finish(0, 8'h00);
    chk("R8 no irq", {31'h0, host_irq}, 0);
    host_rd(8'h04, 0, 32'h00005A04, "R4 done ok");

    // read-style command with interrupt request
    host_wr(8'h00, 32'h000211FF);
    chk("R2 doorbell 2", {31'h0, rsp_doorbell}, 1);
    host_rd(8'h04, 0, 32'h00005A15, "R4 sub echo busy");
    rsp_ib(2'd0, 32'hDDCCBBAA);
    rsp_ib(2'd1, 32'h44332211);
    rsp_finish(0, 8'h00);
    chk("R8 irq pulse", {31'h0, host_irq}, 1);
    @(negedge clk);
    chk("R8 irq single", {31'h0, host_irq}, 0);
    host_rd(8'h04, 0, 32'h00005A14, "R4 read done");
    host_rd(8'h90, 0, 32'hDDCCBBAA, "R7 word0");
    host_rd(8'h94, 0, 32'h44332211, "R7 word1");
    host_rd(8'h91, 1, 32'h000000BB, "R7 byte1");
    host_rd(8'h97, 1, 32'h00000044, "R7 byte7");
    host_rd(8'h90, 1, 32'h000000AA, "R7 byte0");

    // read-modify-write style command, failing, no interrupt requested
    host_wr(8'h00, 32'h000420FF);
    rsp_finish(1, 8'h3C);
    chk("R8 no irq rmw", {31'h0, host_irq}, 0);
    host_rd(8'h04, 0, 32'h003C5A26, "R4 error report");

    // R10 stray completion while idle
    rsp_finish(1, 8'h77);
    chk("R10 no irq", {31'h0, host_irq}, 0);
    host_rd(8'h04, 0, 32'h003C5A26, "R10 status kept");

    // R9 unmapped and read-only
    host_rd(8'h00, 0, 32'h0, "R9 cmd reads zero");
    host_rd(8'h80, 0, 32'h0, "R9 outbound reads zero");
    host_rd(8'h40, 0, 32'h0, "R9 hole reads zero");
    host_wr(8'h04, 32'hFFFFFFFF);
    host_rd(8'h04, 0, 32'h003C5A26, "R9 status write ignored");
    host_wr(8'h94, 32'h12345678);
    host_rd(8'h94, 0, 32'h44332211, "R9 inbound write ignored");

    // R4 new command clears error fields
    host_wr(8'h00, 32'h000000F4);
    host_rd(8'h04, 0, 32'h00005A05, "R4 error cleared");
    rsp_finish(0, 8'h00);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule